// File: doc/BRIEF.md
# ADC Converter Status Register with Debug-Port Lock Arbitration

This block is the read-only status word of a sampling ADC controller, reached over a simple register bus at byte offset 0x04. It turns single-cycle event pulses from the converter into bus-visible flags: a busy bit that spans each conversion, end-of-conversion and end-of-sequence flags that stay set until software reads the word, and the mux channel of the most recently finished conversion.

The same block mirrors the state of a second, debug-side access path to the shared configuration port. It shows whether that path is busy and whether it holds the lock. It also keeps a sticky flag that records a configuration write made from the debug side. Configuration accesses from the fabric side pass through the block's arbitration. A request made while the debug-side lock is held is refused with a one-cycle error pulse. An accepted request is granted, and the grant is the only event that clears the sticky modification flag.

Top module: `adcstat_top`

## Requirements
- R1: After reset every status bit reads 0, `rd_valid` and `rd_data` are 0, and neither `cfg_grant` nor `cfg_err` is asserted.
- R2: A bus read (`bus_valid`=1, `bus_write`=0) at byte offset 0x04 sets `rd_valid` one cycle later. `rd_data` then holds the status word as it stood in the cycle of the read. Its layout, counted from bit 0 as the least significant bit, is: [4:0] channel, [5] end of conversion, [6] end of sequence, [7] ADC busy, [8] debug locked, [9] debug modified, [10] debug busy. Bits [31:11] read 0.
- R3: A bus write to offset 0x04 changes no status bit and produces no `rd_valid`.
- R4: `conv_end` sets the end-of-conversion flag in the next cycle. A status read clears it.
- R5: `seq_end` sets the end-of-sequence flag in the next cycle. A status read clears it.
- R6: When a setting event and a status read fall in the same cycle, that read returns the old value and the flag stays set afterwards.
- R7: The channel field captures `mux_chan` on `conv_end` and holds its value at all other times.
- R8: ADC busy rises on `conv_start` and falls on `conv_end`. If both arrive in the same cycle, busy stays high.
- R9: The debug-busy and debug-locked bits follow `dbg_busy` and `dbg_lock_req` with one cycle of delay.
- R10: `dbg_wr_done` sets the debug-modified bit. Reads do not clear it.
- R11: A `cfg_req` while the locked bit is 1 gives a one-cycle `cfg_err` in the next cycle, no `cfg_grant`, and leaves the modified bit set.
- R12: A `cfg_req` while the locked bit is 0 gives a one-cycle `cfg_grant` in the next cycle and clears the modified bit. A `dbg_wr_done` in the same cycle keeps the bit set.
- R13: A read at any offset other than 0x04 returns 0 and clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Registered read data |
| conv_start | input | 1 | Conversion start pulse |
| conv_end | input | 1 | Conversion end pulse, result written |
| seq_end | input | 1 | Last channel of the automatic sequence written |
| mux_chan | input | 5 | Mux channel of the current conversion |
| dbg_busy | input | 1 | Debug-side transaction in progress |
| dbg_lock_req | input | 1 | Debug side requests the configuration-port lock |
| dbg_wr_done | input | 1 | Debug side completed a configuration write |
| cfg_req | input | 1 | Fabric-side configuration access request pulse |
| cfg_grant | output | 1 | Request accepted |
| cfg_err | output | 1 | Request refused because of the lock |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions. In one, a status read lands in the very cycle that a conversion finishes. In the other, the debug side completes a write in the cycle that a fabric access is granted. The stimulus raises the read strobe and the event pulse on the same falling edge. It then expects the stale word on that read and the set flag on the read that follows. The lock-refusal path is reached by holding the lock request across a fabric request. A status read afterwards confirms that the refused access left the modified bit intact.

// File: rtl/adcstat_pkg.sv
// Shared constants and the status word packer for the ADC status block.
// Assumes a 32-bit bus word and a 5-bit channel field at the bottom.
package adcstat_pkg;
    localparam int WORD_W        = 32;
    localparam int CHAN_W        = 5;
    localparam int STATUS_OFFSET = 4;

    // Field positions the bus side decodes.
    localparam int POS_EOC      = CHAN_W;
    localparam int POS_EOS      = CHAN_W + 1;
    localparam int POS_ADC_BUSY = CHAN_W + 2;
    localparam int POS_DBG_LOCK = CHAN_W + 3;
    localparam int POS_DBG_MOD  = CHAN_W + 4;
    localparam int POS_DBG_BUSY = CHAN_W + 5;

    typedef struct packed {
        logic              dbg_busy;
        logic              dbg_mod;
        logic              dbg_lock;
        logic              adc_busy;
        logic              eos;
        logic              eoc;
        logic [CHAN_W-1:0] chan;
    } stat_t;

    // Place each status field at its bus bit; unused bits are zero.
    function automatic logic [WORD_W-1:0] status_word(stat_t s);
        logic [WORD_W-1:0] w;
        w                  = '0;
        w[CHAN_W-1:0]      = s.chan;
        w[POS_EOC]         = s.eoc;
        w[POS_EOS]         = s.eos;
        w[POS_ADC_BUSY]    = s.adc_busy;
        w[POS_DBG_LOCK]    = s.dbg_lock;
        w[POS_DBG_MOD]     = s.dbg_mod;
        w[POS_DBG_BUSY]    = s.dbg_busy;
        return w;
    endfunction
endpackage

// File: rtl/adcstat_sticky.sv
// One event flag: set by a pulse, cleared by a clear strobe, set wins.
// Assumes both inputs are synchronous single-cycle strobes.
module adcstat_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold the flag; a same-cycle set overrides the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= 1'b0;
        else        flag_o <= set_i | (flag_o & ~clr_i);
    end
endmodule

// File: rtl/adcstat_conv_track.sv
// Tracks converter events: busy window, end-of-conversion and
// end-of-sequence flags, and the channel of the last finished conversion.
// Assumes event pulses last one cycle.
module adcstat_conv_track
    import adcstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              conv_end,
    input  logic              seq_end,
    input  logic [CHAN_W-1:0] mux_chan,
    input  logic              rd_clr,
    output logic              adc_busy,
    output logic              eoc,
    output logic              eos,
    output logic [CHAN_W-1:0] chan
);
    localparam int N_FLAGS = 2;

    logic [N_FLAGS-1:0] flag_set;
    logic [N_FLAGS-1:0] flag_q;

    assign flag_set = {seq_end, conv_end};

    // One clear-on-read flag per converter event.
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        adcstat_sticky u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[g]),
            .clr_i  (rd_clr),
            .flag_o (flag_q[g])
        );
    end

    assign eoc = flag_q[0];
    assign eos = flag_q[1];

    // Busy spans start to end; a new start in the end cycle keeps it high.
    always_ff @(posedge clk) begin
        if (!rst_n) adc_busy <= 1'b0;
        else        adc_busy <= conv_start | (adc_busy & ~conv_end);
    end

    // Capture the mux channel when a conversion completes.
    always_ff @(posedge clk) begin
        if (!rst_n)        chan <= '0;
        else if (conv_end) chan <= mux_chan;
    end
endmodule

// File: rtl/adcstat_dbg_arb.sv
// Mirrors the debug-side path state, keeps the sticky modified flag and
// arbitrates fabric configuration requests against the debug lock.
// Assumes cfg_req is a single-cycle pulse per access.
module adcstat_dbg_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic dbg_busy,
    input  logic dbg_lock_req,
    input  logic dbg_wr_done,
    input  logic cfg_req,
    output logic busy_q,
    output logic lock_q,
    output logic mod_q,
    output logic cfg_grant,
    output logic cfg_err
);
    logic accept;

    assign accept = cfg_req & ~lock_q;

    // Register the debug-side indications.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            busy_q <= dbg_busy;
            lock_q <= dbg_lock_req;
        end
    end

    // Answer each fabric request with a grant or a refusal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_grant <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            cfg_grant <= accept;
            cfg_err   <= cfg_req & lock_q;
        end
    end

    // Modified flag: debug write sets, accepted fabric access clears.
    always_ff @(posedge clk) begin
        if (!rst_n) mod_q <= 1'b0;
        else        mod_q <= dbg_wr_done | (mod_q & ~accept);
    end
endmodule

// File: rtl/adcstat_bus_port.sv
// Bus side: decodes the status offset, registers read data one cycle
// later and raises the clear strobe for read-cleared flags.
// Assumes writes carry no effect on this read-only word.
module adcstat_bus_port
    import adcstat_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] status,
    output logic              rd_clr,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    logic is_read;
    logic hit;

    assign is_read = bus_valid & ~bus_write;
    assign hit     = (bus_addr == ADDR_W'(STATUS_OFFSET));
    assign rd_clr  = is_read & hit;

    // Return the snapshot for reads; other offsets read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= is_read;
            rd_data  <= rd_clr ? status : '0;
        end
    end
endmodule

// File: rtl/adcstat_top.sv
// ADC status register with debug-lock arbitration. Joins the converter
// tracker, the debug arbiter and the bus port into one read-only word.
// Assumes a single clock domain for all inputs.
module adcstat_top
    import adcstat_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              conv_start,
    input  logic              conv_end,
    input  logic              seq_end,
    input  logic [4:0]        mux_chan,
    input  logic              dbg_busy,
    input  logic              dbg_lock_req,
    input  logic              dbg_wr_done,
    input  logic              cfg_req,
    output logic              cfg_grant,
    output logic              cfg_err
);
    stat_t             st;
    logic              rd_clr;
    logic [WORD_W-1:0] word;

    adcstat_conv_track u_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .conv_end   (conv_end),
        .seq_end    (seq_end),
        .mux_chan   (mux_chan),
        .rd_clr     (rd_clr),
        .adc_busy   (st.adc_busy),
        .eoc        (st.eoc),
        .eos        (st.eos),
        .chan       (st.chan)
    );

    adcstat_dbg_arb u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_busy     (dbg_busy),
        .dbg_lock_req (dbg_lock_req),
        .dbg_wr_done  (dbg_wr_done),
        .cfg_req      (cfg_req),
        .busy_q       (st.dbg_busy),
        .lock_q       (st.dbg_lock),
        .mod_q        (st.dbg_mod),
        .cfg_grant    (cfg_grant),
        .cfg_err      (cfg_err)
    );

    assign word = status_word(st);

    adcstat_bus_port #(.ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .status    (word),
        .rd_clr    (rd_clr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/adcstat_checks.sv
// Property checker for adcstat_top, attached by bind below.
module adcstat_checks #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_valid,
    input logic              conv_end,
    input logic              dbg_wr_done,
    input logic              cfg_req,
    input logic              cfg_grant,
    input logic              cfg_err,
    input logic              s_eoc,
    input logic              s_lock,
    input logic              s_mod,
    input logic [4:0]        s_chan
);
    logic stat_rd;
    assign stat_rd = bus_valid & ~bus_write & (bus_addr == ADDR_W'(4));

    p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rd_valid);
    p_write_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write) |=> !rd_valid);
    p_eoc_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_end |=> s_eoc);
    p_eoc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !conv_end) |=> !s_eoc);
    p_chan_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_end |=> $stable(s_chan));
    p_mod_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_wr_done |=> s_mod);
    p_lock_refuse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && s_lock) |=> (cfg_err && !cfg_grant));
    p_refused_keeps_mod_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && s_lock && s_mod) |=> s_mod);
    p_grant_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !s_lock && !dbg_wr_done) |=> (cfg_grant && !s_mod));
    p_answer_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_grant && cfg_err));
endmodule

bind adcstat_top adcstat_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .rd_valid    (rd_valid),
    .conv_end    (conv_end),
    .dbg_wr_done (dbg_wr_done),
    .cfg_req     (cfg_req),
    .cfg_grant   (cfg_grant),
    .cfg_err     (cfg_err),
    .s_eoc       (st.eoc),
    .s_lock      (st.dbg_lock),
    .s_mod       (st.dbg_mod),
    .s_chan      (st.chan)
);

// File: tb/tb_adcstat_top.sv
// Scoreboard bench: read tasks queue the expected word, a monitor compares.
module tb_adcstat_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        conv_start = 1'b0, conv_end = 1'b0, seq_end = 1'b0;
    logic [4:0]  mux_chan = '0;
    logic        dbg_busy = 1'b0, dbg_lock_req = 1'b0, dbg_wr_done = 1'b0;
    logic        cfg_req = 1'b0;
    logic        cfg_grant, cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    adcstat_top dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .conv_start(conv_start), .conv_end(conv_end), .seq_end(seq_end),
        .mux_chan(mux_chan), .dbg_busy(dbg_busy), .dbg_lock_req(dbg_lock_req),
        .dbg_wr_done(dbg_wr_done), .cfg_req(cfg_req),
        .cfg_grant(cfg_grant), .cfg_err(cfg_err)
    );

    // Expected word from the layout in R2.
    function automatic logic [31:0] mk(bit db, bit md, bit lk, bit ab,
                                       bit es, bit ec, logic [4:0] ch);
        return {21'b0, db, md, lk, ab, es, ec, ch};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue a read; optionally pulse conv_end with it (R6 collision).
    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag,
                      bit with_end = 1'b0, logic [4:0] ch = '0);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        conv_end = with_end; mux_chan = ch;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0; conv_end = 1'b0;
    endtask

    task automatic wr(logic [7:0] a);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic end_conv(logic [4:0] ch, bit last);
        conv_end = 1'b1; seq_end = last; mux_chan = ch;
        @(negedge clk);
        conv_end = 1'b0; seq_end = 1'b0;
    endtask

    task automatic cfg(bit exp_g, bit exp_e, string tag);
        cfg_req = 1'b1;
        @(negedge clk);
        cfg_req = 1'b0;
        chk(cfg_grant == exp_g && cfg_err == exp_e, tag,
            {30'b0, cfg_grant, cfg_err}, {30'b0, exp_g, exp_e});
    endtask

    // Monitor: compare each returned read with the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected rd_valid", rd_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(rd_data == e, t, rd_data, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!rd_valid && rd_data == 0 && !cfg_grant && !cfg_err, "R1 reset outputs",
            {rd_data[29:0], rd_valid, cfg_grant | cfg_err}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h04, mk(0,0,0,0,0,0,0), "R1 reset status");
        // R8 busy window
        conv_start = 1'b1; @(negedge clk); conv_start = 1'b0;
        rd(8'h04, mk(0,0,0,1,0,0,0), "R8 busy after start");
        // R4/R7 end of conversion captures channel
        end_conv(5'h13, 1'b0);
        rd(8'h04, mk(0,0,0,0,0,1,5'h13), "R4 eoc set, R7 channel");
        rd(8'h04, mk(0,0,0,0,0,0,5'h13), "R4 eoc cleared, R7 hold");
        // R3 write has no effect
        end_conv(5'h07, 1'b0);
        wr(8'h04);
        @(negedge clk);
        rd(8'h04, mk(0,0,0,0,0,1,5'h07), "R3 write ignored");
        // R5 end of sequence
        end_conv(5'h1f, 1'b1);
        rd(8'h04, mk(0,0,0,0,1,1,5'h1f), "R5 eos set");
        rd(8'h04, mk(0,0,0,0,0,0,5'h1f), "R5 eos cleared");
        // R8 start and end together keep busy
        conv_start = 1'b1; @(negedge clk);
        conv_end = 1'b1; mux_chan = 5'h04; @(negedge clk);
        conv_start = 1'b0; conv_end = 1'b0;
        rd(8'h04, mk(0,0,0,1,0,1,5'h04), "R8 back-to-back busy");
        end_conv(5'h1f, 1'b0);
        rd(8'h04, mk(0,0,0,0,0,1,5'h1f), "R8 busy falls");
        // R6 read collides with conversion end
        rd(8'h04, mk(0,0,0,0,0,0,5'h1f), "R6 old value on collision", 1'b1, 5'h02);
        rd(8'h04, mk(0,0,0,0,0,1,5'h02), "R6 flag kept");
        // R13 other offset
        end_conv(5'h03, 1'b0);
        rd(8'h08, 32'h0, "R13 other offset zero");
        rd(8'h04, mk(0,0,0,0,0,1,5'h03), "R13 no clear");
        // R9 debug mirrors
        dbg_busy = 1'b1; dbg_lock_req = 1'b1;
        @(negedge clk);
        rd(8'h04, mk(1,0,1,0,0,0,5'h03), "R9 debug busy and lock");
        // R10 modified set, not cleared by read
        dbg_wr_done = 1'b1; @(negedge clk); dbg_wr_done = 1'b0;
        rd(8'h04, mk(1,1,1,0,0,0,5'h03), "R10 modified set");
        rd(8'h04, mk(1,1,1,0,0,0,5'h03), "R10 read keeps modified");
        // R11 refusal while locked
        cfg(1'b0, 1'b1, "R11 refused while locked");
        rd(8'h04, mk(1,1,1,0,0,0,5'h03), "R11 modified kept");
        // R12 grant after unlock
        dbg_busy = 1'b0; dbg_lock_req = 1'b0;
        @(negedge clk);
        cfg(1'b1, 1'b0, "R12 granted");
        rd(8'h04, mk(0,0,0,0,0,0,5'h03), "R12 modified cleared");
        // R12 debug write with grant keeps modified
        cfg_req = 1'b1; dbg_wr_done = 1'b1;
        @(negedge clk);
        cfg_req = 1'b0; dbg_wr_done = 1'b0;
        chk(cfg_grant && !cfg_err, "R12 grant on collision",
            {30'b0, cfg_grant, cfg_err}, 32'h2);
        rd(8'h04, mk(0,1,0,0,0,0,5'h03), "R12 set wins over grant");
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule